// File: doc/BRIEF.md
# Dual-Write Register File with Constant Entries

This block holds the architectural registers of a small pipelined 16-bit core. It has sixteen entries of sixteen bits. Entry 0 always reads as zero and entry 1 always reads as one, so the instruction encoding can name these constants without spending immediate bits. Entries 2 to 12 are general-purpose storage. Entry 13 is used by software as the return-address register but behaves exactly like a general-purpose entry. Entry 14 holds compare results, and entry 15 is the program counter.

Two combinational read ports serve the operand fetch. Two synchronous write ports let a single instruction update two registers in one cycle. The divide-with-remainder operation needs this, because it writes the quotient to its destination and the remainder back into its second source. The status entry and the program counter also have their own side ports. The compare unit can load the status entry and the fetch logic can load the program counter without using a general write port. Both values are always visible on dedicated outputs.

A fixed priority settles every conflict. For a stored entry this is, highest first: reset, write port 0, write port 1, then the side port.

Top module: `dualwr_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears entries 2 through 15 to zero, `stat_q` and `pc_q` included. Reset takes priority over every write in that cycle.
- R2: Reading address 0 returns 16'h0000 and reading address 1 returns 16'h0001 at all times. Writes to either address through any port are discarded.
- R3: When `wr0_en` is high at a rising edge, `wr0_data` is stored at `wr0_addr`. From the next cycle it is visible on both read ports.
- R4: When both write ports are enabled with different addresses in one cycle, both entries are updated at that edge.
- R5: When both write ports are enabled with the same address in one cycle, the entry takes `wr0_data`.
- R6: Reads are combinational. In a cycle where an entry is being written, a read of that entry returns the value it held before the write.
- R7: When `stat_we` is high, entry 14 (`stat_q`) takes `stat_wdata` at the edge. A general write port that targets address 14 in the same cycle takes priority over it.
- R8: When `pc_load` is high, entry 15 (`pc_q`) takes `pc_next` at the edge. A general write port that targets address 15 in the same cycle takes priority over it. `pc_q` and `stat_q` always equal what the read ports return for addresses 15 and 14.
- R9: In a cycle with no enable asserted and no reset, every entry keeps its value, whatever the address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr_a | input | 4 | Read port A address |
| rd_data_a | output | 16 | Read port A data (combinational) |
| rd_addr_b | input | 4 | Read port B address |
| rd_data_b | output | 16 | Read port B data (combinational) |
| wr0_en | input | 1 | Write port 0 enable (highest-priority write) |
| wr0_addr | input | 4 | Write port 0 address |
| wr0_data | input | 16 | Write port 0 data |
| wr1_en | input | 1 | Write port 1 enable |
| wr1_addr | input | 4 | Write port 1 address |
| wr1_data | input | 16 | Write port 1 data |
| stat_we | input | 1 | Status side-port enable |
| stat_wdata | input | 16 | Status side-port data |
| stat_q | output | 16 | Current status entry (14) |
| pc_load | input | 1 | Program-counter side-port load enable |
| pc_next | input | 16 | Program-counter load value |
| pc_q | output | 16 | Current program counter (entry 15) |

## Verification
The assertions assume three things. Reset is asserted at the first rising edge. All inputs are driven to known values and change only away from the rising edge. Every address is in range, which the power-of-two depth guarantees. The bench holds reset for the first edge and changes every input just after the falling edge. It sweeps all 256 pairs of write addresses, so the same-address and constant-address cases come up for both ports. In the idle cycles it drives junk on the address and data lines while all enables are low, which tests that enables alone gate every update.

// File: rtl/rf_pkg.sv
package rf_pkg;

   typedef enum logic [2:0] {
      RF_KIND_ZERO,
      RF_KIND_ONE,
      RF_KIND_GENERAL,
      RF_KIND_STATUS,
      RF_KIND_PC
   } rf_kind_e;

   // Role of each entry: two constants at the bottom, status and PC at the top.
   function automatic rf_kind_e rf_kind_of(input int idx, input int nregs);
      if (idx == 0)              return RF_KIND_ZERO;
      else if (idx == 1)         return RF_KIND_ONE;
      else if (idx == nregs - 1) return RF_KIND_PC;
      else if (idx == nregs - 2) return RF_KIND_STATUS;
      else                       return RF_KIND_GENERAL;
   endfunction

endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
   parameter int NUM_REGS = 16,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic                en,
   input  logic [IDX_W-1:0]    addr,
   output logic [NUM_REGS-1:0] hit
);
   always_comb begin
      hit = '0;
      if (en) hit[addr] = 1'b1;
   end
endmodule

// File: rtl/rf_entry.sv
module rf_entry #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hit0,
   input  logic              hit1,
   input  logic [DATA_W-1:0] wd0,
   input  logic [DATA_W-1:0] wd1,
   input  logic              side_en,
   input  logic [DATA_W-1:0] side_d,
   output logic [DATA_W-1:0] q
);
   // Priority: reset, port 0, port 1, side port.
   always_ff @(posedge clk) begin
      if (rst)          q <= '0;
      else if (hit0)    q <= wd0;
      else if (hit1)    q <= wd1;
      else if (side_en) q <= side_d;
   end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
   parameter int DATA_W   = 16,
   parameter int NUM_REGS = 16,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
   input  logic [IDX_W-1:0]                addr,
   output logic [DATA_W-1:0]               data
);
   assign data = regs[addr];
endmodule

// File: rtl/dualwr_regfile.sv
module dualwr_regfile #(
   parameter int DATA_W   = 16,
   parameter int NUM_REGS = 16,
   localparam int IDX_W    = $clog2(NUM_REGS),
   localparam int STAT_IDX = NUM_REGS - 2,
   localparam int PC_IDX   = NUM_REGS - 1,
   localparam int NUM_RD   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IDX_W-1:0]  rd_addr_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [IDX_W-1:0]  rd_addr_b,
   output logic [DATA_W-1:0] rd_data_b,
   input  logic              wr0_en,
   input  logic [IDX_W-1:0]  wr0_addr,
   input  logic [DATA_W-1:0] wr0_data,
   input  logic              wr1_en,
   input  logic [IDX_W-1:0]  wr1_addr,
   input  logic [DATA_W-1:0] wr1_data,
   input  logic              stat_we,
   input  logic [DATA_W-1:0] stat_wdata,
   output logic [DATA_W-1:0] stat_q,
   input  logic              pc_load,
   input  logic [DATA_W-1:0] pc_next,
   output logic [DATA_W-1:0] pc_q
);
   import rf_pkg::*;

   // Elaboration-time parameter checks
   if (NUM_REGS < 5) begin : g_bad_depth
      $error("dualwr_regfile: NUM_REGS must leave room for constants, status and PC");
   end
   if ((1 << IDX_W) != NUM_REGS) begin : g_bad_pow2
      $error("dualwr_regfile: NUM_REGS must be a power of two");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("dualwr_regfile: DATA_W must be at least 2");
   end

   logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
   logic [NUM_REGS-1:0]             hit0, hit1;

   rf_wr_decode #(.NUM_REGS(NUM_REGS)) u_dec0 (
      .en(wr0_en), .addr(wr0_addr), .hit(hit0)
   );
   rf_wr_decode #(.NUM_REGS(NUM_REGS)) u_dec1 (
      .en(wr1_en), .addr(wr1_addr), .hit(hit1)
   );

   // Decoded hits that land on constant entries are dropped (R2).
   logic unused_const_hits;
   assign unused_const_hits = ^{hit0[1:0], hit1[1:0]};

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_entry
      localparam rf_kind_e KIND = rf_kind_of(k, NUM_REGS);
      if (KIND == RF_KIND_ZERO) begin : g_zero
         assign regs_q[k] = '0;
      end else if (KIND == RF_KIND_ONE) begin : g_one
         assign regs_q[k] = DATA_W'(1);
      end else if (KIND == RF_KIND_STATUS) begin : g_stat
         rf_entry #(.DATA_W(DATA_W)) u_reg (
            .clk(clk), .rst(rst),
            .hit0(hit0[k]), .hit1(hit1[k]),
            .wd0(wr0_data), .wd1(wr1_data),
            .side_en(stat_we), .side_d(stat_wdata),
            .q(regs_q[k])
         );
      end else if (KIND == RF_KIND_PC) begin : g_pc
         rf_entry #(.DATA_W(DATA_W)) u_reg (
            .clk(clk), .rst(rst),
            .hit0(hit0[k]), .hit1(hit1[k]),
            .wd0(wr0_data), .wd1(wr1_data),
            .side_en(pc_load), .side_d(pc_next),
            .q(regs_q[k])
         );
      end else begin : g_gen
         rf_entry #(.DATA_W(DATA_W)) u_reg (
            .clk(clk), .rst(rst),
            .hit0(hit0[k]), .hit1(hit1[k]),
            .wd0(wr0_data), .wd1(wr1_data),
            .side_en(1'b0), .side_d('0),
            .q(regs_q[k])
         );
      end
   end

   logic [NUM_RD-1:0][IDX_W-1:0]  rd_addr;
   logic [NUM_RD-1:0][DATA_W-1:0] rd_data;
   assign rd_addr[0] = rd_addr_a;
   assign rd_addr[1] = rd_addr_b;

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      rf_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_port (
         .regs(regs_q), .addr(rd_addr[p]), .data(rd_data[p])
      );
   end

   assign rd_data_a = rd_data[0];
   assign rd_data_b = rd_data[1];
   assign stat_q    = regs_q[STAT_IDX];
   assign pc_q      = regs_q[PC_IDX];

endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
   parameter int DATA_W   = 16,
   parameter int NUM_REGS = 16,
   localparam int IDX_W    = $clog2(NUM_REGS),
   localparam int STAT_IDX = NUM_REGS - 2,
   localparam int PC_IDX   = NUM_REGS - 1
) (
   input logic              clk,
   input logic              rst,
   input logic [IDX_W-1:0]  rd_addr_a,
   input logic [DATA_W-1:0] rd_data_a,
   input logic [IDX_W-1:0]  rd_addr_b,
   input logic [DATA_W-1:0] rd_data_b,
   input logic              wr0_en,
   input logic [IDX_W-1:0]  wr0_addr,
   input logic [DATA_W-1:0] wr0_data,
   input logic              wr1_en,
   input logic [IDX_W-1:0]  wr1_addr,
   input logic [DATA_W-1:0] wr1_data,
   input logic              stat_we,
   input logic [DATA_W-1:0] stat_wdata,
   input logic [DATA_W-1:0] stat_q,
   input logic              pc_load,
   input logic [DATA_W-1:0] pc_next,
   input logic [DATA_W-1:0] pc_q
);
   logic w0_stat, w1_stat, w0_pc, w1_pc;
   assign w0_stat = wr0_en && (wr0_addr == IDX_W'(STAT_IDX));
   assign w1_stat = wr1_en && (wr1_addr == IDX_W'(STAT_IDX));
   assign w0_pc   = wr0_en && (wr0_addr == IDX_W'(PC_IDX));
   assign w1_pc   = wr1_en && (wr1_addr == IDX_W'(PC_IDX));

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (stat_q == '0 && pc_q == '0));

   a_r2_zero_reads: assert property (@(posedge clk) disable iff (rst)
      (rd_addr_a == '0) |-> (rd_data_a == '0));

   a_r2_one_reads: assert property (@(posedge clk) disable iff (rst)
      (rd_addr_b == IDX_W'(1)) |-> (rd_data_b == DATA_W'(1)));

   a_r3_port0_pc: assert property (@(posedge clk) disable iff (rst)
      w0_pc |=> (pc_q == $past(wr0_data)));

   a_r5_port0_wins: assert property (@(posedge clk) disable iff (rst)
      (w0_stat && w1_stat) |=> (stat_q == $past(wr0_data)));

   a_r7_status_side: assert property (@(posedge clk) disable iff (rst)
      (stat_we && !w0_stat && !w1_stat) |=> (stat_q == $past(stat_wdata)));

   a_r7_general_over_status: assert property (@(posedge clk) disable iff (rst)
      (stat_we && w1_stat && !w0_stat) |=> (stat_q == $past(wr1_data)));

   a_r8_pc_load: assert property (@(posedge clk) disable iff (rst)
      (pc_load && !w0_pc && !w1_pc) |=> (pc_q == $past(pc_next)));

   a_r8_pc_mirror: assert property (@(posedge clk) disable iff (rst)
      (rd_addr_a == IDX_W'(PC_IDX)) |-> (rd_data_a == pc_q));

   a_r9_pc_hold: assert property (@(posedge clk) disable iff (rst)
      (!pc_load && !w0_pc && !w1_pc) |=> $stable(pc_q));

   a_r9_stat_hold: assert property (@(posedge clk) disable iff (rst)
      (!stat_we && !w0_stat && !w1_stat) |=> $stable(stat_q));
endmodule

bind dualwr_regfile rf_checker #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf_checker (
   .clk(clk), .rst(rst),
   .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
   .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
   .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
   .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data),
   .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_q(stat_q),
   .pc_load(pc_load), .pc_next(pc_next), .pc_q(pc_q)
);

// File: tb/tb_dualwr_regfile.sv
`timescale 1ns/1ps
module tb_dualwr_regfile;
   localparam int DW = 16;
   localparam int NR = 16;
   localparam int IW = 4;
   localparam int ST = 14;
   localparam int PC = 15;

   logic          clk = 1'b0;
   logic          rst;
   logic [IW-1:0] rd_addr_a, rd_addr_b, wr0_addr, wr1_addr;
   logic [DW-1:0] rd_data_a, rd_data_b, wr0_data, wr1_data;
   logic          wr0_en, wr1_en, stat_we, pc_load;
   logic [DW-1:0] stat_wdata, stat_q, pc_next, pc_q;

   always #2 clk = ~clk;

   dualwr_regfile dut (
      .clk(clk), .rst(rst),
      .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
      .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
      .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
      .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data),
      .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_q(stat_q),
      .pc_load(pc_load), .pc_next(pc_next), .pc_q(pc_q)
   );

   logic [DW-1:0] model [NR];
   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic quiet();
      wr0_en = 1'b0; wr1_en = 1'b0; stat_we = 1'b0; pc_load = 1'b0;
   endtask

   // Expected next state from the requirement priorities (R1, R5, R7, R8).
   task automatic cycle();
      logic [DW-1:0] nxt [NR];
      for (int k = 0; k < NR; k++) begin
         nxt[k] = model[k];
         if (k >= 2) begin
            if (rst)                               nxt[k] = '0;
            else if (wr0_en && int'(wr0_addr) == k) nxt[k] = wr0_data;
            else if (wr1_en && int'(wr1_addr) == k) nxt[k] = wr1_data;
            else if (k == ST && stat_we)          nxt[k] = stat_wdata;
            else if (k == PC && pc_load)          nxt[k] = pc_next;
         end
      end
      @(posedge clk);
      for (int k = 0; k < NR; k++) model[k] = nxt[k];
      @(negedge clk);
   endtask

   task automatic check_all(input string req);
      for (int a = 0; a < NR; a++) begin
         rd_addr_a = IW'(a);
         rd_addr_b = IW'(NR - 1 - a);
         #0.2;
         chk(req, rd_data_a, model[a]);
         chk(req, rd_data_b, model[NR - 1 - a]);
      end
      chk(req, stat_q, model[ST]);
      chk(req, pc_q, model[PC]);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < NR; k++) model[k] = 'x;
      model[0] = '0; model[1] = DW'(1);
      rst = 1'b1; quiet();
      rd_addr_a = '0; rd_addr_b = '0;
      wr0_addr = '0; wr1_addr = '0; wr0_data = '0; wr1_data = '0;
      stat_wdata = '0; pc_next = '0;
      @(negedge clk);
      cycle();
      rst = 1'b0;
      check_all("R1 reset state");

      // R3 / R6 / R2: port 0 writes every address
      for (int i = 0; i < NR; i++) begin
         wr0_en = 1'b1; wr0_addr = IW'(i);
         wr0_data = DW'(i * 16'h1111) ^ 16'hA5A5;
         rd_addr_a = IW'(i);
         #0.5 chk("R6 read old during write", rd_data_a, model[i]);
         cycle();
         quiet();
         #0.5 chk(i < 2 ? "R2 constant write discarded" : "R3 port0 write", rd_data_a, model[i]);
      end
      check_all("R3 full readback");

      // R4 / R5 / R2: every pair of write addresses
      for (int a = 0; a < NR; a++) begin
         for (int b = 0; b < NR; b++) begin
            wr0_en = 1'b1; wr0_addr = IW'(a); wr0_data = DW'(a * 4099 + b * 77 + 1);
            wr1_en = 1'b1; wr1_addr = IW'(b); wr1_data = DW'(b * 811 + a * 13 + 16'h5000);
            rd_addr_a = IW'(a); rd_addr_b = IW'(b);
            #0.5;
            chk("R6 port A old value", rd_data_a, model[a]);
            chk("R6 port B old value", rd_data_b, model[b]);
            cycle();
            quiet();
            #0.5;
            chk(a == b ? "R5 same address port0 wins" : (a < 2 ? "R2 constant" : "R4 dual write A"),
                rd_data_a, model[a]);
            chk(b < 2 ? "R2 constant via port1" : "R4 dual write B", rd_data_b, model[b]);
            chk("R8 pc mirror", pc_q, model[PC]);
         end
      end

      // R7: status side port
      stat_we = 1'b1; stat_wdata = 16'h3C3C;
      cycle(); quiet();
      chk("R7 status side write", stat_q, 16'h3C3C);
      stat_we = 1'b1; stat_wdata = 16'h1111;
      wr0_en = 1'b1; wr0_addr = IW'(ST); wr0_data = 16'hBEEF;
      cycle(); quiet();
      chk("R7 port0 over status", stat_q, 16'hBEEF);
      stat_we = 1'b1; stat_wdata = 16'h2222;
      wr1_en = 1'b1; wr1_addr = IW'(ST); wr1_data = 16'hCAFE;
      cycle(); quiet();
      chk("R7 port1 over status", stat_q, 16'hCAFE);
      stat_we = 1'b1; stat_wdata = 16'h7777;
      wr0_en = 1'b1; wr0_addr = IW'(5); wr0_data = 16'h0505;
      cycle(); quiet();
      chk("R7 status with other write", stat_q, 16'h7777);
      rd_addr_a = IW'(ST);
      #0.5 chk("R7 read port sees status", rd_data_a, model[ST]);

      // R8: program counter side port
      pc_load = 1'b1; pc_next = 16'h0100;
      cycle(); quiet();
      chk("R8 pc load", pc_q, 16'h0100);
      pc_load = 1'b1; pc_next = 16'h0200;
      wr1_en = 1'b1; wr1_addr = IW'(PC); wr1_data = 16'h0ABC;
      cycle(); quiet();
      chk("R8 port1 over pc load", pc_q, 16'h0ABC);
      pc_load = 1'b1; pc_next = 16'h0300;
      wr0_en = 1'b1; wr0_addr = IW'(PC); wr0_data = 16'h0DEF;
      cycle(); quiet();
      chk("R8 port0 over pc load", pc_q, 16'h0DEF);
      rd_addr_b = IW'(PC);
      #0.5 chk("R8 read port sees pc", rd_data_b, model[PC]);

      // R9: junk on address and data lines, all enables low
      for (int c = 0; c < 20; c++) begin
         wr0_addr = IW'(c); wr1_addr = IW'(c + 3);
         wr0_data = DW'(c * 997); wr1_data = DW'(~(c * 31));
         stat_wdata = DW'(c * 5); pc_next = DW'(c * 9);
         cycle();
      end
      check_all("R9 idle hold");

      // R1: reset wins over writes in the same cycle
      rst = 1'b1;
      wr0_en = 1'b1; wr0_addr = IW'(6); wr0_data = 16'hFFFF;
      pc_load = 1'b1; pc_next = 16'h1234;
      stat_we = 1'b1; stat_wdata = 16'h4321;
      cycle(); quiet(); rst = 1'b0;
      check_all("R1 reset over writes");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule